// File: doc/BRIEF.md
# Switchable Serial Baud Tick Source

This block produces the 16x oversampling tick that the variable-rate modes of an asynchronous serial port run on. The tick can come from one of two places. The first is a free-running reload counter clocked by the oscillator clock. Its divisor is loaded one byte at a time through a narrow write port. The second is an overflow pulse from an external timer. That pulse either passes through as it is or is halved by a toggle stage.

A select input picks the source. The result leaves the block as a registered one-clock pulse. A mode-aware gate then passes that pulse only when the serial port is in one of its two variable-rate modes. The fixed-rate modes keep their own clock division, so the gate blocks the pulse for them.

Software halts the reload counter with its run enable before it writes the divisor. While halted, the counter holds the complete divisor as its preset. When it restarts, the first period therefore has the full length, and a half-written divisor never reaches the count.

Top module: `baud_src_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no source event, `src_tick` and `baud_tick` are low.
- R2: A pulse on bit i of `div_wr_en` stores `div_wr_data` into divisor bits [8i+7:8i]. With `src_sel`=1 and `gen_en` raised at cycle N (divisor D), ticks appear at cycles N+1+D+k(D+1).
- R3: A divisor of 0 gives a tick on every cycle while the counter runs.
- R4: A divisor written while the counter runs does not cut short the period in progress. It is used from the next reload, once both bytes are in place.
- R5: While `gen_en` is low, the counter gives no tick and holds the stored divisor as its preset. A restart at cycle N again gives the first tick at N+1+D.
- R6: With `src_sel`=0, counter expiries are ignored. With `src_sel`=1, timer overflow pulses are ignored.
- R7: With `src_sel`=0 and `dbl_rate`=1, each `tmr_ovf` pulse at cycle P gives a tick at cycle P+1, including back-to-back pulses.
- R8: With `src_sel`=0 and `dbl_rate`=0, only every second overflow pulse gives a tick, one cycle later.
- R9: Any change of `src_sel` or `dbl_rate` clears the halving phase. After the change, the first overflow gives no tick and the second one does.
- R10: `ser_mode` encodes 0 = synchronous shift, 1 = 8-bit variable rate, 2 = 9-bit fixed rate, 3 = 9-bit variable rate. `var_mode` is high only for modes 1 and 3. `baud_tick` follows `src_tick` only then.
- R11: Each source event gives a tick that is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr_en | input | DIV_BYTES | Per-byte divisor write strobe, bit i = byte i |
| div_wr_data | input | BYTE_W | Divisor write data |
| gen_en | input | 1 | Run enable of the reload counter |
| src_sel | input | 1 | 1 = reload counter, 0 = timer overflow |
| dbl_rate | input | 1 | 1 = overflow undivided, 0 = overflow halved |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| ser_mode | input | 2 | Serial mode code |
| src_tick | output | 1 | Registered tick of the selected source |
| var_mode | output | 1 | High in the variable-rate modes |
| baud_tick | output | 1 | Tick gated by the mode |

## Verification
The bench builds the block at its defaults of two 8-bit divisor bytes. The full 16-bit divisor path is exercised with a divisor whose high byte is non-zero (259) over a run of a few periods. Small divisors of 0, 3, 4, 5 and 9 keep the other runs short, so the periods, the reload point after a mid-run write and the restart after a halt can all be checked to the exact cycle.

// File: rtl/baud_src_pkg.sv
package baud_src_pkg;

  typedef enum logic [1:0] {
    SER_SYNC = 2'd0,
    SER_VAR8 = 2'd1,
    SER_FIX9 = 2'd2,
    SER_VAR9 = 2'd3
  } ser_mode_e;

  function automatic logic mode_uses_var(input logic [1:0] m);
    return (m == SER_VAR8) || (m == SER_VAR9);
  endfunction

endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int BYTE_W    = 8,
  parameter int DIV_BYTES = 2,
  localparam int DIV_W    = BYTE_W * DIV_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_BYTES-1:0] wr_en,
  input  logic [BYTE_W-1:0]    wr_data,
  output logic [DIV_W-1:0]     divisor
);

  for (genvar i = 0; i < DIV_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (wr_en[i]) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign divisor[i*BYTE_W +: BYTE_W] = byte_q;
  end

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             expire
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = run && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = reload;
    else if (at_zero) cnt_d = reload;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/baud_ovf_halver.sv
module baud_ovf_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic src_sel,
  input  logic dbl_rate,
  output logic ovf_pulse,
  output logic phase
);

  logic sel_q;
  logic dbl_q;
  logic half_q;
  logic half_d;
  logic cfg_change;

  assign cfg_change = (sel_q != src_sel) || (dbl_q != dbl_rate);
  assign ovf_pulse  = ovf && !cfg_change && (dbl_rate || half_q);
  assign phase      = half_q;

  always_comb begin
    half_d = half_q;
    if (cfg_change)             half_d = 1'b0;
    else if (ovf && !dbl_rate)  half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      dbl_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      sel_q  <= src_sel;
      dbl_q  <= dbl_rate;
      half_q <= half_d;
    end
  end

endmodule

// File: rtl/baud_src_gen.sv
module baud_src_gen
  import baud_src_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int DIV_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_BYTES-1:0] div_wr_en,
  input  logic [BYTE_W-1:0]    div_wr_data,
  input  logic                 gen_en,
  input  logic                 src_sel,
  input  logic                 dbl_rate,
  input  logic                 tmr_ovf,
  input  logic [1:0]           ser_mode,
  output logic                 src_tick,
  output logic                 var_mode,
  output logic                 baud_tick
);

  localparam int DIV_W = BYTE_W * DIV_BYTES;

  logic [DIV_W-1:0] divisor;
  logic             gen_expire;
  logic             tmr_pulse;
  logic             half_phase;
  logic             tick_d;
  logic             tick_q;

  baud_div_reg #(.BYTE_W(BYTE_W), .DIV_BYTES(DIV_BYTES)) u_divreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (div_wr_en),
    .wr_data (div_wr_data),
    .divisor (divisor)
  );

  baud_div_counter #(.DIV_W(DIV_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (gen_en),
    .reload (divisor),
    .expire (gen_expire)
  );

  baud_ovf_halver u_halver (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf       (tmr_ovf),
    .src_sel   (src_sel),
    .dbl_rate  (dbl_rate),
    .ovf_pulse (tmr_pulse),
    .phase     (half_phase)
  );

  always_comb begin
    tick_d = tmr_pulse;
    if (src_sel) tick_d = gen_expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign src_tick  = tick_q;
  assign var_mode  = mode_uses_var(ser_mode);
  assign baud_tick = tick_q && var_mode;

endmodule

// File: rtl/baud_src_gen_chk.sv
module baud_src_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic gen_en,
  input logic src_sel,
  input logic dbl_rate,
  input logic tmr_ovf,
  input logic src_tick,
  input logic half_phase
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R5: a counter tick needs the counter running in the cycle before
  a_r5_halted_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick && $past(src_sel)) |-> $past(gen_en));

  // R6: a timer-path tick needs an overflow pulse in the cycle before
  a_r6_timer_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick && !$past(src_sel)) |-> $past(tmr_ovf));

  // R7: undivided overflow under a settled configuration ticks next cycle
  a_r7_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(tmr_ovf) && !$past(src_sel) && $past(dbl_rate)
     && $past(src_sel) == $past(src_sel, 2)
     && $past(dbl_rate) == $past(dbl_rate, 2)) |-> src_tick);

  // R8: a halved tick needs the phase armed by an earlier overflow
  a_r8_halved_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick && !$past(src_sel) && !$past(dbl_rate)) |-> $past(half_phase));

  // R9: a configuration change leaves the phase cleared
  a_r9_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && (src_sel != $past(src_sel) || dbl_rate != $past(dbl_rate)))
    |=> !half_phase);

endmodule

bind baud_src_gen baud_src_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gen_en     (gen_en),
  .src_sel    (src_sel),
  .dbl_rate   (dbl_rate),
  .tmr_ovf    (tmr_ovf),
  .src_tick   (src_tick),
  .half_phase (half_phase)
);

// File: tb/baud_src_gen_test.sv
module baud_src_gen_test;

  localparam int BYTE_W    = 8;
  localparam int DIV_BYTES = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [DIV_BYTES-1:0] div_wr_en = '0;
  logic [BYTE_W-1:0]    div_wr_data = '0;
  logic                 gen_en = 1'b0;
  logic                 src_sel = 1'b1;
  logic                 dbl_rate = 1'b0;
  logic                 tmr_ovf = 1'b0;
  logic [1:0]           ser_mode = 2'd1;
  logic                 src_tick;
  logic                 var_mode;
  logic                 baud_tick;

  baud_src_gen #(.BYTE_W(BYTE_W), .DIV_BYTES(DIV_BYTES)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_wr_en   (div_wr_en),
    .div_wr_data (div_wr_data),
    .gen_en      (gen_en),
    .src_sel     (src_sel),
    .dbl_rate    (dbl_rate),
    .tmr_ovf     (tmr_ovf),
    .ser_mode    (ser_mode),
    .src_tick    (src_tick),
    .var_mode    (var_mode),
    .baud_tick   (baud_tick)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    exp_q[$];
  string cur_req = "R1";
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every observed tick is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && baud_tick) begin
      int e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: tick at cycle %0d, expected no tick", cur_req, cyc);
      end else begin
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL %s: tick at cycle %0d, expected cycle %0d", cur_req, cyc, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic drain();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d ticks outstanding (next at %0d), expected 0",
               cur_req, exp_q.size(), exp_q[0]);
      exp_q.delete();
    end
  endtask

  task automatic write_div(input int v);
    div_wr_en = 2'b01; div_wr_data = v[7:0];  step(1);
    div_wr_en = 2'b10; div_wr_data = v[15:8]; step(1);
    div_wr_en = 2'b00;
  endtask

  task automatic run_gen(input int d, input int len);
    int n;
    write_div(d);
    step(3);
    n = cyc;
    gen_en = 1'b1;
    for (int t = n + 1 + d; t <= n + len; t += d + 1) exp_q.push_back(t);
    wait_until(n + len);
    gen_en = 1'b0;
    step(3);
    drain();
  endtask

  task automatic pulse_ovf(input bit expect_tick);
    if (expect_tick) exp_q.push_back(cyc + 1);
    tmr_ovf = 1'b1;
    step(1);
    tmr_ovf = 1'b0;
  endtask

  initial begin
    int n, n2, t2;
    step(2);
    cur_req = "R1";
    chk("R1 src_tick in reset", src_tick, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 src_tick after reset", src_tick, 0);
    chk("R1 baud_tick after reset", baud_tick, 0);

    // R2: low byte only, then both bytes
    cur_req = "R2"; ser_mode = 2'd1;
    run_gen(5, 40);
    cur_req = "R2"; ser_mode = 2'd3;
    run_gen(259, 800);

    // R3: divisor zero
    cur_req = "R3";
    run_gen(0, 10);

    // R4: rewrite while running
    cur_req = "R4";
    write_div(4);
    step(3);
    n = cyc;
    gen_en = 1'b1;
    t2 = n + 15;
    exp_q.push_back(n + 5);
    exp_q.push_back(n + 10);
    exp_q.push_back(n + 15);
    for (int t = t2 + 5; t <= t2 + 40; t += 10) exp_q.push_back(t);
    wait_until(t2);
    write_div(9);
    wait_until(t2 + 40);
    gen_en = 1'b0;
    step(3);
    drain();

    // R5: halt mid-period, restart gives a full first period
    cur_req = "R5";
    write_div(3);
    step(3);
    n = cyc;
    gen_en = 1'b1;
    exp_q.push_back(n + 4);
    wait_until(n + 6);
    gen_en = 1'b0;
    step(10);
    drain();
    n2 = cyc;
    gen_en = 1'b1;
    exp_q.push_back(n2 + 4);
    exp_q.push_back(n2 + 8);
    exp_q.push_back(n2 + 12);
    wait_until(n2 + 13);
    gen_en = 1'b0;
    step(3);
    drain();

    // R6: the unselected source is ignored
    cur_req = "R6";
    write_div(2);
    src_sel = 1'b0; dbl_rate = 1'b1;
    step(3);
    gen_en = 1'b1;
    step(30);
    chk("R6 counter ignored when timer selected", src_tick, 0);
    gen_en = 1'b0;
    src_sel = 1'b1;
    step(3);
    pulse_ovf(0); step(2);
    pulse_ovf(0); step(2);
    chk("R6 overflow ignored when counter selected", src_tick, 0);
    step(3);
    drain();

    // R7 / R11: undivided overflow, spaced and back to back
    cur_req = "R7";
    src_sel = 1'b0; dbl_rate = 1'b1;
    step(3);
    pulse_ovf(1);
    chk("R11 tick high one cycle after pulse", src_tick, 1);
    step(1);
    chk("R11 tick gone the next cycle", src_tick, 0);
    step(2);
    pulse_ovf(1);
    pulse_ovf(1);
    step(3);
    drain();

    // R8: halved overflow
    cur_req = "R8";
    dbl_rate = 1'b0;
    step(3);
    pulse_ovf(0); step(2);
    pulse_ovf(1); step(2);
    pulse_ovf(0); step(2);
    pulse_ovf(1); step(3);
    drain();

    // R9: configuration change clears the phase
    cur_req = "R9";
    pulse_ovf(0); step(2);
    dbl_rate = 1'b1; step(2);
    dbl_rate = 1'b0; step(2);
    pulse_ovf(0); step(2);
    pulse_ovf(1); step(2);
    pulse_ovf(0); step(2);
    src_sel = 1'b1; step(2);
    src_sel = 1'b0; step(2);
    pulse_ovf(0); step(2);
    pulse_ovf(1); step(3);
    drain();

    // R10: mode gating
    cur_req = "R10";
    dbl_rate = 1'b1;
    step(3);
    for (int m = 0; m < 4; m++) begin
      ser_mode = m[1:0];
      step(1);
      chk("R10 var_mode", var_mode, (m == 1 || m == 3) ? 1 : 0);
      pulse_ovf(m == 1 || m == 3);
      chk("R10 src_tick present in every mode", src_tick, 1);
      chk("R10 baud_tick gated", baud_tick, (m == 1 || m == 3) ? 1 : 0);
      step(2);
    end
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run still active at cycle %0d, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule